// File: doc/BRIEF.md
# Flash ECC Error Status Capture

This unit keeps the error status that the read path of a flash memory controller reports. Three event strobes come in from the read side: a correctable fault that the decoder has repaired, an uncorrectable fault, and a read that returned invalid data because the addressed block was busy with a flash command. Each qualifying event sets a sticky flag. Software reads the flags and clears them through a byte-wide register port.

An event is first taken into a pending stage. It reaches the visible flags one clock later, so a status read in the cycle right after the faulting read still returns the old value. An event is accepted only while its own flag is clear. While a flag stays set, further events of that kind are lost. A configuration input can mask all reporting of correctable faults. When the single-fault flag is set and the enable input is high, the unit raises an interrupt request.

Top module: `ecc_fault_status`

## Requirements
- R1: After reset the status byte reads 0x00. Bits 7 to 2 always read 0, and writes to those bits change nothing.
- R2: Once set, a flag holds its value until it is cleared by a write.
- R3: Writing a 1 to bit 0 or bit 1 clears that flag. Writing a 0 to a bit leaves that flag unchanged.
- R4: An uncorrectable-fault strobe sets bit 1 (the double-fault flag).
- R5: A corrected-fault strobe sets bit 0 (the single-fault flag) when the ignore input is 0.
- R6: When the ignore input is 1, corrected-fault strobes are dropped and never set bit 0, not even after the ignore input returns to 0. A busy-block read in that state sets bit 1 only.
- R7: A busy-block read with the ignore input at 0 sets both bit 0 and bit 1.
- R8: A strobe sampled at clock edge n shows in the status byte only after edge n+1. A read between those two edges still returns the previous value.
- R9: A strobe that arrives while its flag is already set is not recorded. After the flag is cleared, it stays clear.
- R10: A write-1 clear in the same cycle that a pending event would set the same flag leaves the flag clear.
- R11: The interrupt output is high exactly when bit 0 is set and the interrupt-enable input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the status byte |
| reg_wdata | input | 8 | Write data; a 1 in bit 0 or bit 1 clears that flag |
| reg_rdata | output | 8 | Status byte: bit 1 double fault, bit 0 single fault |
| ecc_sb_evt | input | 1 | Corrected single-bit fault on a read |
| ecc_db_evt | input | 1 | Uncorrectable fault on a read |
| busy_rd_evt | input | 1 | Read of a block that is running a flash command |
| cfg_sb_ignore | input | 1 | Masks single-fault reporting |
| sb_irq_en | input | 1 | Interrupt enable for the single-fault flag |
| sb_irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear and a capture that collide. A strobe has to be waiting in the pending stage at the very edge where software writes a 1 to the same flag. The bench creates this by pulsing a corrected-fault strobe on one edge and placing the clearing write on the next edge. It then checks that the flag is clear after that edge and still clear one edge later. The rule that drops events while a flag is set is also checked at the ports. The bench sets the double-fault flag, pulses a second strobe, clears the flag once the stage has drained, and confirms that nothing comes back.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;

    localparam int FLAG_NUM = 2;
    localparam int SB_BIT   = 0;
    localparam int DB_BIT   = 1;

    typedef logic [FLAG_NUM-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t pend;
    } stage_regs_t;

    typedef struct packed {
        flag_vec_t flag;
    } bank_regs_t;

endpackage

// File: rtl/ecc_evt_stage.sv
module ecc_evt_stage
    import ecc_fault_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sb_evt,
    input  logic      db_evt,
    input  logic      busy_evt,
    input  logic      ignore_sb,
    input  flag_vec_t flag_q,
    output flag_vec_t pend_q
);

    stage_regs_t r_d, r_q;
    flag_vec_t   raw;

    // Qualify the incoming strobes, then keep only those whose flag is clear now.
    always_comb begin
        raw         = '0;
        raw[SB_BIT] = (sb_evt | busy_evt) & ~ignore_sb;
        raw[DB_BIT] = db_evt | busy_evt;
        r_d         = r_q;
        r_d.pend    = raw & ~flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pend_q = r_q.pend;

    AST_IGNORE_DROPS_SB: assert property (@(posedge clk) disable iff (!rst_n)
        ignore_sb |=> !pend_q[SB_BIT]); // R6

    AST_BUSY_RAISES_DB: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_evt && !flag_q[DB_BIT]) |=> pend_q[DB_BIT]); // R7

    for (genvar i = 0; i < FLAG_NUM; i++) begin : g_gate_chk
        AST_GATED_WHILE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[i] |=> !pend_q[i]); // R9
    end

endmodule

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank
    import ecc_fault_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t pend_q,
    input  flag_vec_t clr_mask,
    output flag_vec_t flag_q
);

    bank_regs_t r_d, r_q;

    // Sticky set from the stage; a clear in the same cycle takes priority.
    always_comb begin
        r_d      = r_q;
        r_d.flag = (r_q.flag | pend_q) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flag_q = r_q.flag;

    for (genvar i = 0; i < FLAG_NUM; i++) begin : g_flag_chk
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[i] |=> !flag_q[i]); // R10

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_mask[i]) |=> flag_q[i]); // R2

        AST_SET_VIA_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(pend_q[i])); // R8
    end

endmodule

// File: rtl/ecc_fault_status.sv
module ecc_fault_status
    import ecc_fault_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ecc_sb_evt,
    input  logic             ecc_db_evt,
    input  logic             busy_rd_evt,
    input  logic             cfg_sb_ignore,
    input  logic             sb_irq_en,
    output logic             sb_irq
);

    localparam int RSVD_W = REG_W - FLAG_NUM;

    flag_vec_t pend_q;
    flag_vec_t flag_q;
    flag_vec_t clr_mask;

    assign clr_mask = reg_wr ? reg_wdata[FLAG_NUM-1:0] : '0;

    ecc_evt_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .sb_evt    (ecc_sb_evt),
        .db_evt    (ecc_db_evt),
        .busy_evt  (busy_rd_evt),
        .ignore_sb (cfg_sb_ignore),
        .flag_q    (flag_q),
        .pend_q    (pend_q)
    );

    ecc_flag_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_q   (pend_q),
        .clr_mask (clr_mask),
        .flag_q   (flag_q)
    );

    assign reg_rdata = {{RSVD_W{1'b0}}, flag_q};
    assign sb_irq    = flag_q[SB_BIT] & sb_irq_en;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_irq_en |-> !sb_irq); // R11

endmodule

// File: tb/ecc_fault_status_bench.sv
module ecc_fault_status_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ecc_sb_evt = 1'b0;
    logic       ecc_db_evt = 1'b0;
    logic       busy_rd_evt = 1'b0;
    logic       cfg_sb_ignore = 1'b0;
    logic       sb_irq_en = 1'b0;
    logic       sb_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_fault_status u_ecc_fault_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ecc_sb_evt    (ecc_sb_evt),
        .ecc_db_evt    (ecc_db_evt),
        .busy_rd_evt   (busy_rd_evt),
        .cfg_sb_ignore (cfg_sb_ignore),
        .sb_irq_en     (sb_irq_en),
        .sb_irq        (sb_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic sb, input logic db, input logic bz);
        ecc_sb_evt = sb; ecc_db_evt = db; busy_rd_evt = bz;
        step();
        ecc_sb_evt = 1'b0; ecc_db_evt = 1'b0; busy_rd_evt = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", reg_rdata, 8'h00);
        check("R11 reset irq", {7'd0, sb_irq}, 8'h00);
    endtask

    task automatic t_double();
        pulse(1'b0, 1'b1, 1'b0);
        check("R8 not yet visible", reg_rdata, 8'h00);
        step();
        check("R4 double set", reg_rdata, 8'h02);
        repeat (4) step();
        check("R2 sticky", reg_rdata, 8'h02);
        wr(8'h00);
        check("R3 write zero", reg_rdata, 8'h02);
        wr(8'hFC);
        check("R1 reserved write", reg_rdata, 8'h02);
        wr(8'h02);
        check("R3 clear", reg_rdata, 8'h00);
    endtask

    task automatic t_single_irq();
        sb_irq_en = 1'b1;
        pulse(1'b1, 1'b0, 1'b0);
        check("R8 single pending", reg_rdata, 8'h00);
        step();
        check("R5 single set", reg_rdata, 8'h01);
        check("R11 irq on", {7'd0, sb_irq}, 8'h01);
        sb_irq_en = 1'b0;
        #1;
        check("R11 irq masked", {7'd0, sb_irq}, 8'h00);
        wr(8'h01);
        check("R3 single clear", reg_rdata, 8'h00);
    endtask

    task automatic t_ignore();
        cfg_sb_ignore = 1'b1;
        pulse(1'b1, 1'b0, 1'b0);
        cfg_sb_ignore = 1'b0;
        step(); step();
        check("R6 single dropped", reg_rdata, 8'h00);
        cfg_sb_ignore = 1'b1;
        pulse(1'b0, 1'b0, 1'b1);
        step();
        cfg_sb_ignore = 1'b0;
        check("R6 busy masked", reg_rdata, 8'h02);
        wr(8'h02);
        check("R3 after ignore", reg_rdata, 8'h00);
    endtask

    task automatic t_busy();
        pulse(1'b0, 1'b0, 1'b1);
        step();
        check("R7 busy both", reg_rdata, 8'h03);
        wr(8'h03);
        check("R3 clear both", reg_rdata, 8'h00);
    endtask

    task automatic t_gate();
        pulse(1'b0, 1'b1, 1'b0);
        step();
        check("R9 first set", reg_rdata, 8'h02);
        pulse(1'b0, 1'b1, 1'b0);
        step();
        wr(8'h02);
        step(); step();
        check("R9 lost while set", reg_rdata, 8'h00);
    endtask

    task automatic t_clear_wins();
        pulse(1'b1, 1'b0, 1'b0);
        wr(8'h01);
        check("R10 clear wins", reg_rdata, 8'h00);
        step();
        check("R10 stays clear", reg_rdata, 8'h00);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_double();
        t_single_irq();
        t_ignore();
        t_busy();
        t_gate();
        t_clear_wins();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule